// File: doc/BRIEF.md
# ADC Conversion Result Register with Overrun Detection

This block holds the most recent result delivered by an analog-to-digital conversion sequencer. Each time the sequencer raises its one-cycle completion pulse, the block stores the 10-bit result. It also raises a data-ready flag and an interrupt-factor flag. If a new result lands before software has read the previous one, the old value is still replaced, and a sticky overrun flag records that data was lost.

Software reaches the block through a small register bus. Reads are one byte wide and combinational. Writes carry four bits. Reading the low result byte consumes the data and drops the ready flag. The two flags that software clears are cleared by writing 0 to their bit. The interrupt request is the interrupt-factor flag gated by an enable bit. It can drive an interrupt controller or serve as a DMA request.

Top module: `adc_result_reg`

## Requirements
- R1: After reset the result is 0, the ready, overrun and interrupt-factor flags are 0, the interrupt enable is 0 and `irq_o` is 0.
- R2: A cycle with `done_i`=1 stores `result_i` and sets both the ready flag and the interrupt-factor flag on that clock edge.
- R3: A completion that arrives while ready is 1 sets the overrun flag, and the new result replaces the old one.
- R4: A completion that arrives while ready is 0 does not set the overrun flag.
- R5: A read at address 0 returns result bits 7:0 and clears ready. If a completion falls in the same cycle as that read, ready stays 1.
- R6: Once overrun is set, it stays set until a write to address 2 with bit 0 = 0. Writing 1 to bit 0 has no effect. A completion in the same cycle as the clearing write wins. When overrun rises, ready is 1.
- R7: The interrupt-factor flag is cleared only by a write to address 2 with bit 2 = 0. Writing 1 to bit 2 has no effect. A completion in the same cycle as the clearing write wins.
- R8: A read at address 1 returns result bits 9:8 in data bits 1:0, with the upper bits 0. It does not change ready.
- R9: A read at address 2 returns the status byte: bit 0 overrun, bit 1 ready, bit 2 interrupt-factor, bit 3 interrupt enable, bits 7:4 zero. Every write to address 2 loads the enable from write bit 3. Ready is read-only. Address 3 reads 0.
- R10: `irq_o` is 1 exactly when both the interrupt-factor flag and the enable are 1.
- R11: Reads at addresses 1, 2 and 3 have no side effect on any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| done_i | input | 1 | Conversion-complete pulse from the sequencer |
| result_i | input | 10 | Conversion result, valid with `done_i` |
| addr_i | input | 2 | Register address |
| rd_i | input | 1 | Read strobe (side effects only; read data is always driven) |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 4 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| irq_o | output | 1 | Interrupt / DMA request |

## Verification
A completion pulse can land in the same cycle as one of two software actions. The first is a low-byte read that would clear ready. The second is a status write that clears overrun or the interrupt factor. The bench provokes both collisions on purpose, and its random phase drives completions, reads and writes independently. In both collisions the set must win. The behavioural model computes the set-over-clear outcome on its own, and the bench compares the read data and the request line with that model on every cycle.

// File: rtl/adc_res_pkg.sv
package adc_res_pkg;

    // Register addresses and status bit positions
    localparam int ADR_LO   = 0;
    localparam int ADR_HI   = 1;
    localparam int ADR_STAT = 2;

    localparam int BIT_OVR  = 0;
    localparam int BIT_RDY  = 1;
    localparam int BIT_IFAC = 2;
    localparam int BIT_IEN  = 3;

    typedef struct packed {
        logic rdy;
        logic ovr;
    } cap_flags_t;

    typedef struct packed {
        logic ifac;
        logic ien;
    } irq_state_t;

endpackage

// File: rtl/adc_res_capture.sv
module adc_res_capture
    import adc_res_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [DATA_W-1:0] result_i,
    input  logic              rd_lo_i,
    input  logic              clr_ovr_i,
    output logic [DATA_W-1:0] res_o,
    output logic              rdy_o,
    output logic              ovr_o
);

    logic [DATA_W-1:0] res_d, res_q;
    cap_flags_t        flg_d, flg_q;

    always_comb begin
        res_d = res_q;
        flg_d = flg_q;
        // software clears first, completion overrides
        if (rd_lo_i)   flg_d.rdy = 1'b0;
        if (clr_ovr_i) flg_d.ovr = 1'b0;
        if (done_i) begin
            res_d     = result_i;
            flg_d.rdy = 1'b1;
            if (flg_q.rdy) flg_d.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
            flg_q <= '0;
        end else begin
            res_q <= res_d;
            flg_q <= flg_d;
        end
    end

    assign res_o = res_q;
    assign rdy_o = flg_q.rdy;
    assign ovr_o = flg_q.ovr;

endmodule

// File: rtl/adc_res_irq.sv
module adc_res_irq
    import adc_res_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic done_i,
    input  logic wr_stat_i,
    input  logic wr_ifac_i,
    input  logic wr_ien_i,
    output logic ifac_o,
    output logic ien_o,
    output logic irq_o
);

    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_stat_i) begin
            st_d.ien = wr_ien_i;
            if (!wr_ifac_i) st_d.ifac = 1'b0;
        end
        if (done_i) st_d.ifac = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ifac_o = st_q.ifac;
    assign ien_o  = st_q.ien;
    assign irq_o  = st_q.ifac & st_q.ien;

endmodule

// File: rtl/adc_res_rdmux.sv
module adc_res_rdmux
    import adc_res_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int ADDR_W = 2
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] res_i,
    input  logic              rdy_i,
    input  logic              ovr_i,
    input  logic              ifac_i,
    input  logic              ien_i,
    output logic [7:0]        rdata_o
);

    localparam int HI_W = DATA_W - 8;

    logic [7:0] hi_byte;
    logic [7:0] stat_byte;

    generate
        if (HI_W >= 8) begin : g_hi_full
            assign hi_byte = res_i[15:8];
        end else begin : g_hi_part
            assign hi_byte = {{(8-HI_W){1'b0}}, res_i[DATA_W-1:8]};
        end
    endgenerate

    always_comb begin
        stat_byte           = '0;
        stat_byte[BIT_OVR]  = ovr_i;
        stat_byte[BIT_RDY]  = rdy_i;
        stat_byte[BIT_IFAC] = ifac_i;
        stat_byte[BIT_IEN]  = ien_i;
    end

    always_comb begin
        unique case (int'(addr_i))
            ADR_LO:   rdata_o = res_i[7:0];
            ADR_HI:   rdata_o = hi_byte;
            ADR_STAT: rdata_o = stat_byte;
            default:  rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg
    import adc_res_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [DATA_W-1:0] result_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [3:0]        wdata_i,
    output logic [7:0]        rdata_o,
    output logic              irq_o
);

    logic              rd_lo, wr_stat;
    logic [DATA_W-1:0] res_w;
    logic              rdy_w, ovr_w, ifac_w, ien_w;

    assign rd_lo   = rd_i && (int'(addr_i) == ADR_LO);
    assign wr_stat = wr_i && (int'(addr_i) == ADR_STAT);

    adc_res_capture #(.DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_i    (done_i),
        .result_i  (result_i),
        .rd_lo_i   (rd_lo),
        .clr_ovr_i (wr_stat && !wdata_i[BIT_OVR]),
        .res_o     (res_w),
        .rdy_o     (rdy_w),
        .ovr_o     (ovr_w)
    );

    adc_res_irq u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .done_i    (done_i),
        .wr_stat_i (wr_stat),
        .wr_ifac_i (wdata_i[BIT_IFAC]),
        .wr_ien_i  (wdata_i[BIT_IEN]),
        .ifac_o    (ifac_w),
        .ien_o     (ien_w),
        .irq_o     (irq_o)
    );

    adc_res_rdmux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mux (
        .addr_i  (addr_i),
        .res_i   (res_w),
        .rdy_i   (rdy_w),
        .ovr_i   (ovr_w),
        .ifac_i  (ifac_w),
        .ien_i   (ien_w),
        .rdata_o (rdata_o)
    );

endmodule

// File: rtl/adc_result_reg_chk.sv
module adc_result_reg_chk #(
    parameter int DATA_W = 10,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done_i,
    input logic [DATA_W-1:0] result_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic              rd_i,
    input logic              wr_i,
    input logic [3:0]        wdata_i,
    input logic              irq_o,
    input logic [DATA_W-1:0] res,
    input logic              rdy,
    input logic              ovr,
    input logic              ifac,
    input logic              ien
);

    logic stat_wr, ovr_clr, ifac_clr;
    assign stat_wr  = wr_i && (int'(addr_i) == 2);
    assign ovr_clr  = stat_wr && !wdata_i[0];
    assign ifac_clr = stat_wr && !wdata_i[2];

    p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> (res == $past(result_i)) && rdy && ifac);

    p_overrun_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done_i && rdy |=> ovr);

    p_no_overrun_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done_i && !rdy && !ovr |=> !ovr);

    p_rd_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i && (int'(addr_i) == 0) && !done_i |=> !rdy);

    p_ovr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovr && !ovr_clr |=> ovr);

    p_ovr_with_rdy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> rdy);

    p_ifac_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ifac && !ifac_clr |=> ifac);

    p_hi_read_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rdy && !(rd_i && (int'(addr_i) == 0)) |=> rdy);

    p_irq_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ifac) && ien |-> irq_o);

    p_irq_masked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !ien |-> !irq_o);

endmodule

bind adc_result_reg adc_result_reg_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .done_i   (done_i),
    .result_i (result_i),
    .addr_i   (addr_i),
    .rd_i     (rd_i),
    .wr_i     (wr_i),
    .wdata_i  (wdata_i),
    .irq_o    (irq_o),
    .res      (res_w),
    .rdy      (rdy_w),
    .ovr      (ovr_w),
    .ifac     (ifac_w),
    .ien      (ien_w)
);

// File: tb/adc_result_reg_test.sv
module adc_result_reg_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       done_i = 1'b0;
    logic [9:0] result_i = '0;
    logic [1:0] addr_i = '0;
    logic       rd_i = 1'b0;
    logic       wr_i = 1'b0;
    logic [3:0] wdata_i = '0;
    logic [7:0] rdata_o;
    logic       irq_o;

    always #2.5 clk = ~clk;

    adc_result_reg uut (
        .clk(clk), .rst_n(rst_n), .done_i(done_i), .result_i(result_i),
        .addr_i(addr_i), .rd_i(rd_i), .wr_i(wr_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .irq_o(irq_o)
    );

    // behavioural reference state
    int m_res, m_rdy, m_ovr, m_ifac, m_ien;
    int n_chk = 0;
    int n_fail = 0;
    string tag = "R1";
    bit finished = 0;

    function automatic int model_read(int a);
        case (a)
            0: return m_res % 256;
            1: return m_res / 256;
            2: return m_ovr + 2*m_rdy + 4*m_ifac + 8*m_ien;
            default: return 0;
        endcase
    endfunction

    task automatic check(string req, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // one bus cycle: drive at falling edge, compare, then advance the model at the rising edge
    task automatic cyc(bit d, int r, bit rd, bit wr, int a, int wd);
        int nres, nrdy, novr, nifac, nien;
        @(negedge clk);
        done_i = d; result_i = 10'(r); rd_i = rd; wr_i = wr;
        addr_i = 2'(a); wdata_i = 4'(wd);
        #1;
        check(tag, int'(rdata_o), model_read(a), "rdata");           // R9 R8 R5 layout
        check("R10", int'(irq_o), m_ifac & m_ien, "irq");
        nres = m_res; nrdy = m_rdy; novr = m_ovr; nifac = m_ifac; nien = m_ien;
        if (rd && a == 0) nrdy = 0;
        if (wr && a == 2) begin
            nien = (wd >> 3) & 1;
            if ((wd & 1) == 0) novr = 0;
            if ((wd & 4) == 0) nifac = 0;
        end
        if (d) begin
            nres = r; nifac = 1;
            if (m_rdy == 1) novr = 1;
            nrdy = 1;
        end
        @(posedge clk);
        m_res = nres; m_rdy = nrdy; m_ovr = novr; m_ifac = nifac; m_ien = nien;
    endtask

    task automatic rdq(int a);  cyc(0, 0, 1, 0, a, 0);  endtask
    task automatic wrs(int v);  cyc(0, 0, 0, 1, 2, v);  endtask

    initial begin
        #(5 * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        m_res = 0; m_rdy = 0; m_ovr = 0; m_ifac = 0; m_ien = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state on every address
        tag = "R1";
        for (int a = 0; a < 4; a++) rdq(a + 1 > 3 ? 3 : a + 1);
        rdq(0);
        // R2: capture sets ready and interrupt factor
        tag = "R2";
        cyc(1, 'h2A5, 0, 0, 2, 0);
        rdq(2);
        // R8, R11: high byte read leaves ready
        tag = "R8";
        rdq(1); rdq(1); rdq(2);
        tag = "R11";
        rdq(3); rdq(2);
        // R5: low read clears ready
        tag = "R5";
        rdq(0); rdq(2);
        // R4: completion while not ready leaves overrun clear
        tag = "R4";
        cyc(1, 'h155, 0, 0, 2, 0); rdq(2);
        // R3: second completion sets overrun, overwrites
        tag = "R3";
        cyc(1, 'h3C3, 0, 0, 2, 0); rdq(2); rdq(1); rdq(0); rdq(2);
        // R6: writing 1 keeps overrun, writing 0 clears it
        tag = "R6";
        wrs(4'h5); rdq(2); wrs(4'h4); rdq(2);
        // R6: clearing write colliding with an overrunning completion
        cyc(1, 'h001, 0, 0, 2, 0);
        cyc(1, 'h002, 0, 1, 2, 4'h4); rdq(2);
        // R5: completion in the same cycle as a low read keeps ready
        tag = "R5";
        cyc(1, 'h0F0, 1, 0, 0, 0); rdq(2); rdq(0);
        // R7: factor clear, and set winning over clear
        tag = "R7";
        wrs(4'h1); rdq(2);
        cyc(1, 'h111, 0, 1, 2, 4'h0); rdq(2);
        // R9, R10: enable load and request
        tag = "R10";
        wrs(4'hC); rdq(2); wrs(4'h8); rdq(2);
        cyc(1, 'h222, 0, 0, 1, 0); rdq(2); wrs(4'h4); rdq(2);
        // random mix of completions, reads and writes
        tag = "R9";
        for (int i = 0; i < 3000; i++) begin
            cyc(($urandom % 4) == 0, int'($urandom % 1024), ($urandom % 3) == 0,
                ($urandom % 5) == 0, int'($urandom % 4), int'($urandom % 16));
        end
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule